// File: doc/BRIEF.md
# Operand Address and Cycle Penalty Unit

This unit forms the 16-bit operand address for the addressing modes of a classic 8-bit processor. It also reports how many extra clock cycles the instruction pays for crossing a page or for taking a branch. The sequencer pulses `start` and presents the following on the same cycle:

- the mode code and the one or two operand bytes;
- the X and Y index values;
- a flag that marks opcodes subject to the page-cross penalty;
- for branches, the address of the following instruction and whether the branch condition holds.

Direct modes are settled from these inputs alone. Pointer modes first read two bytes through a single-outstanding read port.

The unit keeps the historical quirks rather than doing plain arithmetic:

- zero-page indexing wraps within page 0;
- two-byte pointer fetches from page 0 wrap from 0xFF back to 0x00;
- an indirect jump through a pointer ending in 0xFF takes its high byte from the start of the same page.

A page is 256 bytes. Two addresses share a page when their upper bytes are equal.

Top module: `ea_penalty_unit`

## Requirements
- R1: Zero-page modes (code 0 plain, 1 adds X, 2 adds Y) produce {0x00, (operand_lo + index) mod 256}, so the address always stays in page 0, and they add no extra cycles.
- R2: Absolute modes (code 3 plain, 4 adds X, 5 adds Y) produce ({operand_hi, operand_lo} + zero-extended index) mod 65536.
- R3: For codes 4, 5 and 8, `extra_cyc` is 1 when the penalty flag is high and the indexed result's upper byte differs from the base's upper byte; otherwise it is 0.
- R4: Indirect jump (code 6) reads the low byte at {hi, lo} and the high byte at {hi, (lo+1) mod 256}. With lo = 0xFF the second read stays in the same page. The address is {second byte, first byte}, with no extra cycles.
- R5: Indexed-indirect (code 7) forms z = (operand_lo + X) mod 256, reads page-0 bytes z and (z+1) mod 256, and returns that pointer with no extra cycles.
- R6: Indirect-indexed (code 8) reads page-0 bytes operand_lo and (operand_lo+1) mod 256, then returns (pointer + Y) mod 65536.
- R7: Relative branch (code 9) returns next_pc + sign-extended operand_lo. `extra_cyc` is 0 when the branch is not taken, 1 when taken to the same page as next_pc, and 2 when taken to a different page.
- R8: The read port has one request outstanding. `mem_req` and `mem_addr` hold until a cycle with `mem_valid` high. The low-byte read always comes before the high-byte read.
- R9: `done` is high for a single cycle with the address and the penalty. For codes 0-5 and 9 it rises one cycle after `start`. For pointer modes it rises one cycle after the second valid response.
- R10: A `start` pulse while a pointer fetch is in progress is ignored. The pending result and the count of `done` pulses are unchanged.
- R11: During and after reset, `done`, `mem_req`, `eff_addr` and `extra_cyc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address calculation |
| mode | input | 4 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte (or branch displacement) |
| opnd_hi | input | 8 | Second operand byte |
| x_reg | input | 8 | X index value |
| y_reg | input | 8 | Y index value |
| pen_en | input | 1 | Opcode takes the page-cross penalty |
| br_taken | input | 1 | Branch condition holds |
| next_pc | input | 16 | Address of the following instruction |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Result strobe |
| eff_addr | output | 16 | Effective address |
| extra_cyc | output | 2 | Extra cycle count |

## Verification
Direct modes and branches deliver their result one cycle after `start`. Pointer modes deliver it one cycle after the second valid read. With a response delay of L cycles per read, that is 5 + 2L cycles after the `start` edge.

The bench drives inputs on the falling edge and counts falling edges until `done`. It compares that count with the expected latency and samples address and penalty on that same falling edge. Read addresses are logged at the first cycle of each request, and their order is checked. After each run the bench watches for a stray second `done`.

// File: rtl/ea_penalty_unit.sv
module ea_penalty_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  opnd_lo,
  input  logic [7:0]  opnd_hi,
  input  logic [7:0]  x_reg,
  input  logic [7:0]  y_reg,
  input  logic        pen_en,
  input  logic        br_taken,
  input  logic [15:0] next_pc,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_valid,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic [15:0] eff_addr,
  output logic [1:0]  extra_cyc
);
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
                         M_ABSX = 4'd4, M_ABSY = 4'd5, M_IND = 4'd6, M_INDX = 4'd7,
                         M_INDY = 4'd8, M_REL = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;
  st_t st;

  logic [3:0]  mode_q;
  logic [7:0]  y_q, lo_q;
  logic        pen_q, done_q;
  logic [15:0] ptr_lo_q, ptr_hi_q, addr_q;
  logic [1:0]  extra_q;

  wire [7:0]  zx    = opnd_lo + x_reg;
  wire [7:0]  zy    = opnd_lo + y_reg;
  wire [7:0]  lo_p1 = opnd_lo + 8'd1;
  wire [7:0]  zx_p1 = zx + 8'd1;
  wire [15:0] base  = {opnd_hi, opnd_lo};
  wire [15:0] absx  = base + {8'h00, x_reg};
  wire [15:0] absy  = base + {8'h00, y_reg};
  wire [15:0] br_t  = next_pc + {{8{opnd_lo[7]}}, opnd_lo};
  wire        is_ptr = (mode == M_IND) || (mode == M_INDX) || (mode == M_INDY);

  wire [15:0] ptr_v = {mem_rdata, lo_q};
  wire [15:0] iy    = ptr_v + {8'h00, y_q};
  wire        iy_x  = pen_q && (iy[15:8] != ptr_v[15:8]);

  logic [15:0] d_addr;
  logic [1:0]  d_extra;

  always_comb begin
    d_addr  = 16'h0000;
    d_extra = 2'd0;
    case (mode)
      M_ZP:   d_addr = {8'h00, opnd_lo};
      M_ZPX:  d_addr = {8'h00, zx};
      M_ZPY:  d_addr = {8'h00, zy};
      M_ABS:  d_addr = base;
      M_ABSX: begin
        d_addr  = absx;
        d_extra = {1'b0, pen_en && (absx[15:8] != opnd_hi)};
      end
      M_ABSY: begin
        d_addr  = absy;
        d_extra = {1'b0, pen_en && (absy[15:8] != opnd_hi)};
      end
      M_REL: begin
        d_addr  = br_t;
        d_extra = !br_taken ? 2'd0 : (br_t[15:8] != next_pc[15:8]) ? 2'd2 : 2'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= 4'd0;
      y_q      <= 8'h00;
      lo_q     <= 8'h00;
      pen_q    <= 1'b0;
      done_q   <= 1'b0;
      ptr_lo_q <= 16'h0000;
      ptr_hi_q <= 16'h0000;
      addr_q   <= 16'h0000;
      extra_q  <= 2'd0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          y_q    <= y_reg;
          pen_q  <= pen_en;
          if (is_ptr) begin
            st <= S_LO;
            case (mode)
              M_IND:   begin ptr_lo_q <= base;          ptr_hi_q <= {opnd_hi, lo_p1}; end
              M_INDX:  begin ptr_lo_q <= {8'h00, zx};   ptr_hi_q <= {8'h00, zx_p1};   end
              default: begin ptr_lo_q <= {8'h00, opnd_lo}; ptr_hi_q <= {8'h00, lo_p1}; end
            endcase
          end else begin
            addr_q  <= d_addr;
            extra_q <= d_extra;
            done_q  <= 1'b1;
          end
        end
        S_LO: if (mem_valid) begin
          lo_q <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: if (mem_valid) begin
          addr_q  <= (mode_q == M_INDY) ? iy : ptr_v;
          extra_q <= {1'b0, (mode_q == M_INDY) && iy_x};
          done_q  <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st != S_IDLE);
  assign mem_addr  = (st == S_HI) ? ptr_hi_q : ptr_lo_q;
  assign done      = done_q;
  assign eff_addr  = addr_q;
  assign extra_cyc = extra_q;

  AST_ZP_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY) |-> eff_addr[15:8] == 8'h00); // R1
  AST_NO_PEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q != M_REL) && !pen_q |-> extra_cyc == 2'd0); // R3
  AST_IND_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (st == S_HI) && (mode_q == M_IND) |-> mem_addr[15:8] == ptr_lo_q[15:8]); // R4
  AST_PTR_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (mode_q == M_INDX || mode_q == M_INDY) |-> mem_addr[15:8] == 8'h00); // R5
  AST_TWO_ONLY_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    done && (extra_cyc == 2'd2) |-> mode_q == M_REL); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R8
endmodule

// File: tb/ea_penalty_unit_tb_top.sv
module ea_penalty_unit_tb_top;
  logic clk = 0, rst_n = 0, start = 0, pen_en = 0, br_taken = 0;
  logic [3:0] mode = 0;
  logic [7:0] opnd_lo = 0, opnd_hi = 0, x_reg = 0, y_reg = 0;
  logic [15:0] next_pc = 0;
  logic mem_req, mem_valid = 0, done;
  logic [15:0] mem_addr, eff_addr;
  logic [7:0] mem_rdata = 0;
  logic [1:0] extra_cyc;

  int n_tests = 0, n_fail = 0, lat = 0, wait_cnt = 0, req_total = 0;
  int got_cyc, req_base;
  logic [15:0] got_addr;
  logic [1:0]  got_extra;
  logic [15:0] req_log [0:255];

  always #10 clk = ~clk;

  ea_penalty_unit dut_i (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .x_reg(x_reg), .y_reg(y_reg), .pen_en(pen_en),
    .br_taken(br_taken), .next_pc(next_pc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr),
    .extra_cyc(extra_cyc));

  function automatic logic [7:0] mf(input logic [15:0] a);
    return 8'(a[7:0] * 8'd3 + a[15:8] * 8'd7 + 8'd1);
  endfunction

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req && !mem_valid) begin
      if (wait_cnt == 0) begin
        req_log[req_total[7:0]] <= mem_addr;
        req_total <= req_total + 1;
      end
      if (wait_cnt == lat) begin
        mem_valid <= 1'b1;
        mem_rdata <= mf(mem_addr);
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                    input logic [7:0] xv, input logic [7:0] yv, input logic pen,
                    input logic tk, input logic [15:0] pc);
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; x_reg = xv; y_reg = yv;
    pen_en = pen; br_taken = tk; next_pc = pc; start = 1;
    req_base = req_total;
    @(negedge clk);
    start = 0; got_cyc = 1;
    while (!done && got_cyc < 60) begin @(negedge clk); got_cyc++; end
    got_addr = eff_addr; got_extra = extra_cyc;
    @(negedge clk);
    chk("R9 single-cycle done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R11 done", {31'd0, done}, 0);
    chk("R11 mem_req", {31'd0, mem_req}, 0);
    chk("R11 eff_addr", {16'd0, eff_addr}, 0);
    chk("R11 extra", {30'd0, extra_cyc}, 0);
    rst_n = 1;
  endtask

  task automatic t_zero_page;
    go(4'd0, 8'h7C, 8'h55, 8'h00, 8'h00, 1, 0, 0);
    chk("R1 zp addr", {16'd0, got_addr}, 32'h007C);
    chk("R9 direct latency", got_cyc, 1);
    go(4'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 1, 0, 0);
    chk("R1 zpx wrap", {16'd0, got_addr}, 32'h0010);
    chk("R1 zpx no extra", {30'd0, got_extra}, 0);
    go(4'd2, 8'hFF, 8'h12, 8'h00, 8'h03, 1, 0, 0);
    chk("R1 zpy wrap", {16'd0, got_addr}, 32'h0002);
  endtask

  task automatic t_absolute;
    go(4'd3, 8'h34, 8'h12, 8'h10, 8'h10, 1, 0, 0);
    chk("R2 abs", {16'd0, got_addr}, 32'h1234);
    go(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 1, 0, 0);
    chk("R2 absx", {16'd0, got_addr}, 32'h1310);
    chk("R3 absx cross pen", {30'd0, got_extra}, 1);
    go(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 0, 0, 0);
    chk("R3 absx cross no pen", {30'd0, got_extra}, 0);
    go(4'd5, 8'h10, 8'h12, 8'h00, 8'h20, 1, 0, 0);
    chk("R3 absy no cross", {30'd0, got_extra}, 0);
    go(4'd5, 8'hF0, 8'hFF, 8'h00, 8'h20, 1, 0, 0);
    chk("R2 absy wrap 16", {16'd0, got_addr}, 32'h0010);
    chk("R3 absy wrap cross", {30'd0, got_extra}, 1);
  endtask

  task automatic t_indirect_jump;
    lat = 2;
    go(4'd6, 8'hFF, 8'h12, 8'h00, 8'h00, 1, 0, 0);
    chk("R4 lo fetch addr", {16'd0, req_log[req_base[7:0]]}, 32'h12FF);
    chk("R4 hi fetch same page", {16'd0, req_log[8'(req_base + 1)]}, 32'h1200);
    chk("R4 quirk target", {16'd0, got_addr}, {16'd0, mf(16'h1200), mf(16'h12FF)});
    chk("R9 pointer latency", got_cyc, 5 + 2 * lat);
    lat = 0;
    go(4'd6, 8'h34, 8'h12, 8'h00, 8'h00, 1, 0, 0);
    chk("R4 normal target", {16'd0, got_addr}, {16'd0, mf(16'h1235), mf(16'h1234)});
    chk("R8 two reads", req_total - req_base, 2);
  endtask

  task automatic t_indexed_indirect;
    lat = 1;
    go(4'd7, 8'hF0, 8'h00, 8'h0F, 8'h00, 1, 0, 0);
    chk("R5 lo at 00FF", {16'd0, req_log[req_base[7:0]]}, 32'h00FF);
    chk("R5 hi wraps 0000", {16'd0, req_log[8'(req_base + 1)]}, 32'h0000);
    chk("R5 target", {16'd0, got_addr}, {16'd0, mf(16'h0000), mf(16'h00FF)});
    chk("R5 no extra", {30'd0, got_extra}, 0);
    lat = 0;
  endtask

  task automatic t_indirect_indexed;
    logic [15:0] p, e;
    p = {mf(16'h0000), mf(16'h00FF)};
    for (int i = 0; i < 3; i++) begin
      logic [7:0] yv;
      logic pen;
      yv  = (i == 0) ? 8'h01 : 8'h05;
      pen = (i != 2);
      e = p + {8'h00, yv};
      go(4'd8, 8'hFF, 8'h00, 8'h00, yv, pen, 0, 0);
      chk("R6 hi wraps", {16'd0, req_log[8'(req_base + 1)]}, 32'h0000);
      chk("R6 target", {16'd0, got_addr}, {16'd0, e});
      chk("R3 indy penalty", {30'd0, got_extra}, {31'd0, pen && (e[15:8] != p[15:8])});
    end
  endtask

  task automatic t_branch;
    go(4'd9, 8'h20, 8'h00, 8'h00, 8'h00, 0, 1, 16'h10F0);
    chk("R7 taken cross addr", {16'd0, got_addr}, 32'h1110);
    chk("R7 taken cross extra", {30'd0, got_extra}, 2);
    go(4'd9, 8'h05, 8'h00, 8'h00, 8'h00, 0, 1, 16'h10F0);
    chk("R7 taken same page", {30'd0, got_extra}, 1);
    go(4'd9, 8'h20, 8'h00, 8'h00, 8'h00, 0, 0, 16'h10F0);
    chk("R7 not taken", {30'd0, got_extra}, 0);
    go(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 0, 1, 16'h1000);
    chk("R7 backward addr", {16'd0, got_addr}, 32'h0F80);
    chk("R7 backward extra", {30'd0, got_extra}, 2);
  endtask

  task automatic t_busy_ignore;
    int dones = 0;
    lat = 3;
    @(negedge clk);
    mode = 4'd7; opnd_lo = 8'hF0; x_reg = 8'h0F; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    mode = 4'd0; opnd_lo = 8'h44; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done) begin
        dones++;
        chk("R10 result kept", {16'd0, eff_addr}, {16'd0, mf(16'h0000), mf(16'h00FF)});
      end
    end
    chk("R10 one done", dones, 1);
    lat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_zero_page;
    t_absolute;
    t_indirect_jump;
    t_indexed_indirect;
    t_indirect_indexed;
    t_branch;
    t_busy_ignore;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule